// File: doc/BRIEF.md
# Line Token Guard

This block sits beside a level-one data cache and keeps a small marker array that says which parts of each resident line hold a secret token value. A token is one wide random constant held in a register. Software marks memory as forbidden by writing that constant over it with a dedicated token store. From then on the marker travels with the data. When a line arrives from the next cache level, every token-sized chunk of it is compared against the register, and each match sets that chunk's marker bit. When a marked line leaves the cache, the token value is written back into the marked chunks, so memory still holds the token.

The core access port carries four operations: load, store, token set and token clear. An ordinary load or store that lands on a marked chunk raises a registered violation flag one cycle later. The flag comes with the line index and byte offset of the access. The token operations change only the marker of the addressed chunk and never fault. The tag and data arrays, replacement, queueing and allocation all stay outside the block. The caller supplies line indices and the raw line data.

Top module: `line_token_guard`

## Requirements
- R1: After reset every marker bit is 0, the violation flag is 0 and the token register holds all ones, so a fill whose chunks are all ones marks those chunks.
- R2: On a fill, the marker bit of each chunk of the addressed line becomes 1 if that chunk equals the token register and 0 otherwise. The result is visible on tok_bits_o from the cycle after the fill edge.
- R3: A token set (acc_op_i = 2) makes the addressed chunk's marker 1, and a token clear (acc_op_i = 3) makes it 0. Neither operation raises a violation, and no other marker bit changes.
- R4: A load (acc_op_i = 0) or store (acc_op_i = 1) whose chunk is marked before the edge drives viol_o to 1 for exactly the next cycle, with viol_idx_o and viol_off_o equal to that access's index and offset. An access to an unmarked chunk leaves viol_o at 0. Neither kind of ordinary access changes any marker.
- R5: While evict_valid_i is 1, wb_data_o equals evict_data_i except that every marked chunk of the evicted line is replaced by the token register value. At the edge, all marker bits of the evicted line become 0.
- R6: A write to the token register takes effect at the edge. A fill in the same cycle still compares against the previous token value.
- R7: When operations target the same line in the same cycle, the fill result overrides a token operation and an eviction, and a token operation overrides the eviction's clearing. A violation is judged on the marker state before the edge.
- R8: Chunk c of a line holds bytes c*TOKEN_BYTES up to (c+1)*TOKEN_BYTES-1, with byte 0 in bits 7:0. An access's chunk is acc_off_i divided by TOKEN_BYTES. The marker for line l, chunk c is tok_bits_o bit l*CHUNKS+c, where CHUNKS is LINE_BYTES/TOKEN_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_we_i | input | 1 | Token register write enable |
| tok_wdata_i | input | TOKEN_BYTES*8 | New token value |
| fill_valid_i | input | 1 | Line fill from next level this cycle |
| fill_idx_i | input | $clog2(LINES) | Line index being filled |
| fill_data_i | input | LINE_BYTES*8 | Incoming line data |
| evict_valid_i | input | 1 | Line eviction this cycle |
| evict_idx_i | input | $clog2(LINES) | Line index being evicted |
| evict_data_i | input | LINE_BYTES*8 | Line data read from the data array |
| wb_data_o | output | LINE_BYTES*8 | Writeback data with token regenerated |
| acc_valid_i | input | 1 | Core access valid |
| acc_op_i | input | 2 | 0 load, 1 store, 2 token set, 3 token clear |
| acc_idx_i | input | $clog2(LINES) | Line index hit by the access |
| acc_off_i | input | $clog2(LINE_BYTES) | Byte offset within the line |
| tok_bits_o | output | LINES*CHUNKS | Marker bits, line-major |
| viol_o | output | 1 | Ordinary access touched a marked chunk (registered) |
| viol_idx_o | output | $clog2(LINES) | Line index of the faulting access |
| viol_off_o | output | $clog2(LINE_BYTES) | Byte offset of the faulting access |

## Verification
A fill and a core access, or a fill and an eviction, can land on the same line in one edge, and so can a token register write and a fill. The bench forces these collisions directly and again through a long random stretch with a narrow index range. One such case is a load to a marked chunk in the same cycle that a non-matching fill clears the chunk. Another is a token clear beside a matching fill. A third is an eviction beside a token set. The behavioural model judges each collision by taking the violation from the marker state before the edge and applying the eviction, then the access, then the fill.

// File: rtl/ltg_pkg.sv
package ltg_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_TSET  = 2'd2,
    OP_TCLR  = 2'd3
  } acc_op_e;
endpackage

// File: rtl/ltg_fill_cmp.sv
module ltg_fill_cmp #(
  parameter int LINE_W = 512,
  parameter int TOK_W  = 256,
  localparam int CHUNKS = LINE_W / TOK_W
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [TOK_W-1:0]  tok_i,
  output logic [CHUNKS-1:0] hit_o
);
  for (genvar c = 0; c < CHUNKS; c++) begin : g_cmp
    assign hit_o[c] = (line_i[c*TOK_W +: TOK_W] == tok_i);
  end
endmodule

// File: rtl/ltg_wb_regen.sv
module ltg_wb_regen #(
  parameter int LINE_W = 512,
  parameter int TOK_W  = 256,
  localparam int CHUNKS = LINE_W / TOK_W
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [TOK_W-1:0]  tok_i,
  input  logic [CHUNKS-1:0] mark_i,
  output logic [LINE_W-1:0] line_o
);
  for (genvar c = 0; c < CHUNKS; c++) begin : g_mux
    assign line_o[c*TOK_W +: TOK_W] = mark_i[c] ? tok_i : line_i[c*TOK_W +: TOK_W];
  end
endmodule

// File: rtl/ltg_meta.sv
module ltg_meta
  import ltg_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int CHUNKS = 2,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 6,
  parameter int CSH    = 5,
  localparam int CW    = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fill_valid_i,
  input  logic [IDX_W-1:0]         fill_idx_i,
  input  logic [CHUNKS-1:0]        fill_hit_i,
  input  logic                     evict_valid_i,
  input  logic [IDX_W-1:0]         evict_idx_i,
  output logic [CHUNKS-1:0]        evict_mark_o,
  input  logic                     acc_valid_i,
  input  acc_op_e                  acc_op_i,
  input  logic [IDX_W-1:0]         acc_idx_i,
  input  logic [OFF_W-1:0]         acc_off_i,
  output logic [LINES*CHUNKS-1:0]  bits_o,
  output logic                     viol_o,
  output logic [IDX_W-1:0]         viol_idx_o,
  output logic [OFF_W-1:0]         viol_off_o
);
  logic [LINES-1:0][CHUNKS-1:0] bits_q, bits_d;
  logic [CW-1:0] acc_ch;
  logic          bad_acc;

  assign acc_ch  = CW'(acc_off_i >> CSH);
  assign bad_acc = acc_valid_i && (acc_op_i inside {OP_LOAD, OP_STORE})
                   && bits_q[acc_idx_i][acc_ch];

  // priority: evict < token op < fill
  always_comb begin
    bits_d = bits_q;
    if (evict_valid_i) bits_d[evict_idx_i] = '0;
    if (acc_valid_i && acc_op_i == OP_TSET) bits_d[acc_idx_i][acc_ch] = 1'b1;
    if (acc_valid_i && acc_op_i == OP_TCLR) bits_d[acc_idx_i][acc_ch] = 1'b0;
    if (fill_valid_i) bits_d[fill_idx_i] = fill_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q     <= '0;
      viol_o     <= 1'b0;
      viol_idx_o <= '0;
      viol_off_o <= '0;
    end else begin
      bits_q <= bits_d;
      viol_o <= bad_acc;
      if (bad_acc) begin
        viol_idx_o <= acc_idx_i;
        viol_off_o <= acc_off_i;
      end
    end
  end

  assign evict_mark_o = bits_q[evict_idx_i];
  assign bits_o       = bits_q;
endmodule

// File: rtl/line_token_guard.sv
module line_token_guard
  import ltg_pkg::*;
#(
  parameter int LINE_BYTES  = 64,
  parameter int TOKEN_BYTES = 32,
  parameter int LINES       = 8,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int TOK_W  = TOKEN_BYTES * 8,
  localparam int CHUNKS = LINE_BYTES / TOKEN_BYTES,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int CSH    = $clog2(TOKEN_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tok_we_i,
  input  logic [TOK_W-1:0]        tok_wdata_i,
  input  logic                    fill_valid_i,
  input  logic [IDX_W-1:0]        fill_idx_i,
  input  logic [LINE_W-1:0]       fill_data_i,
  input  logic                    evict_valid_i,
  input  logic [IDX_W-1:0]        evict_idx_i,
  input  logic [LINE_W-1:0]       evict_data_i,
  output logic [LINE_W-1:0]       wb_data_o,
  input  logic                    acc_valid_i,
  input  logic [1:0]              acc_op_i,
  input  logic [IDX_W-1:0]        acc_idx_i,
  input  logic [OFF_W-1:0]        acc_off_i,
  output logic [LINES*CHUNKS-1:0] tok_bits_o,
  output logic                    viol_o,
  output logic [IDX_W-1:0]        viol_idx_o,
  output logic [OFF_W-1:0]        viol_off_o
);
  logic [TOK_W-1:0]  tok_q;
  logic [CHUNKS-1:0] fill_hit, evict_mark;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tok_q <= '1;
    else if (tok_we_i) tok_q <= tok_wdata_i;
  end

  ltg_fill_cmp #(.LINE_W(LINE_W), .TOK_W(TOK_W)) u_cmp (
    .line_i (fill_data_i),
    .tok_i  (tok_q),
    .hit_o  (fill_hit)
  );

  ltg_wb_regen #(.LINE_W(LINE_W), .TOK_W(TOK_W)) u_regen (
    .line_i (evict_data_i),
    .tok_i  (tok_q),
    .mark_i (evict_mark),
    .line_o (wb_data_o)
  );

  ltg_meta #(
    .LINES(LINES), .CHUNKS(CHUNKS), .IDX_W(IDX_W), .OFF_W(OFF_W), .CSH(CSH)
  ) u_meta (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fill_valid_i  (fill_valid_i),
    .fill_idx_i    (fill_idx_i),
    .fill_hit_i    (fill_hit),
    .evict_valid_i (evict_valid_i),
    .evict_idx_i   (evict_idx_i),
    .evict_mark_o  (evict_mark),
    .acc_valid_i   (acc_valid_i),
    .acc_op_i      (acc_op_e'(acc_op_i)),
    .acc_idx_i     (acc_idx_i),
    .acc_off_i     (acc_off_i),
    .bits_o        (tok_bits_o),
    .viol_o        (viol_o),
    .viol_idx_o    (viol_idx_o),
    .viol_off_o    (viol_off_o)
  );
endmodule

// File: rtl/ltg_checker.sv
module ltg_checker #(
  parameter int LINE_BYTES  = 64,
  parameter int TOKEN_BYTES = 32,
  parameter int LINES       = 8,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int TOK_W  = TOKEN_BYTES * 8,
  localparam int CHUNKS = LINE_BYTES / TOKEN_BYTES,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    fill_valid_i,
  input logic [IDX_W-1:0]        fill_idx_i,
  input logic                    evict_valid_i,
  input logic [IDX_W-1:0]        evict_idx_i,
  input logic [LINE_W-1:0]       evict_data_i,
  input logic [LINE_W-1:0]       wb_data_o,
  input logic                    acc_valid_i,
  input logic [1:0]              acc_op_i,
  input logic [IDX_W-1:0]        acc_idx_i,
  input logic [OFF_W-1:0]        acc_off_i,
  input logic [LINES*CHUNKS-1:0] tok_bits_o,
  input logic                    viol_o,
  input logic [IDX_W-1:0]        viol_idx_o,
  input logic [OFF_W-1:0]        viol_off_o,
  input logic [TOK_W-1:0]        tok_i
);
  int   acc_bit, ev_bit;
  logic acc_marked, ev_marked, ordinary;

  always_comb begin
    acc_bit    = int'(acc_idx_i) * CHUNKS + int'(acc_off_i) / TOKEN_BYTES;
    ev_bit     = int'(evict_idx_i) * CHUNKS;
    acc_marked = tok_bits_o[acc_bit];
    ev_marked  = tok_bits_o[ev_bit];
    ordinary   = acc_valid_i && !acc_op_i[1];
  end

  p_viol_on_mark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ordinary && acc_marked |=> viol_o && viol_idx_o == $past(acc_idx_i)
                               && viol_off_o == $past(acc_off_i));

  p_viol_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(ordinary && acc_marked));

  p_store_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ordinary && !fill_valid_i && !evict_valid_i |=> $stable(tok_bits_o));

  p_tokop_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_op_i[1] |=> !viol_o);

  p_tset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_op_i == 2'd2 && !(fill_valid_i && fill_idx_i == acc_idx_i)
    |=> tok_bits_o[$past(acc_bit)]);

  p_tclr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_op_i == 2'd3 && !(fill_valid_i && fill_idx_i == acc_idx_i)
    |=> !tok_bits_o[$past(acc_bit)]);

  p_wb_regen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && ev_marked |-> wb_data_o[TOK_W-1:0] == tok_i);

  p_wb_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && !ev_marked |-> wb_data_o[TOK_W-1:0] == evict_data_i[TOK_W-1:0]);

  p_evict_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_i && !fill_valid_i && !(acc_valid_i && acc_op_i[1])
    |=> !tok_bits_o[$past(ev_bit)]);
endmodule

bind line_token_guard ltg_checker #(
  .LINE_BYTES(LINE_BYTES), .TOKEN_BYTES(TOKEN_BYTES), .LINES(LINES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fill_valid_i(fill_valid_i), .fill_idx_i(fill_idx_i),
  .evict_valid_i(evict_valid_i), .evict_idx_i(evict_idx_i),
  .evict_data_i(evict_data_i), .wb_data_o(wb_data_o),
  .acc_valid_i(acc_valid_i), .acc_op_i(acc_op_i),
  .acc_idx_i(acc_idx_i), .acc_off_i(acc_off_i),
  .tok_bits_o(tok_bits_o), .viol_o(viol_o),
  .viol_idx_o(viol_idx_o), .viol_off_o(viol_off_o),
  .tok_i(tok_q)
);

// File: tb/line_token_guard_bench.sv
`timescale 1ns/1ps
module line_token_guard_bench;
  localparam int LB = 64, TB = 32, NL = 8;
  localparam int LW = LB * 8, TW = TB * 8, CH = LB / TB;
  localparam int IW = $clog2(NL), OW = $clog2(LB);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic tok_we;  logic [TW-1:0] tok_wdata;
  logic fill_valid; logic [IW-1:0] fill_idx; logic [LW-1:0] fill_data;
  logic evict_valid; logic [IW-1:0] evict_idx; logic [LW-1:0] evict_data;
  logic [LW-1:0] wb_data;
  logic acc_valid; logic [1:0] acc_op; logic [IW-1:0] acc_idx; logic [OW-1:0] acc_off;
  logic [NL*CH-1:0] tok_bits;
  logic viol; logic [IW-1:0] viol_idx; logic [OW-1:0] viol_off;

  line_token_guard #(.LINE_BYTES(LB), .TOKEN_BYTES(TB), .LINES(NL)) u_line_token_guard (
    .clk_i(clk), .rst_ni(rst_n), .tok_we_i(tok_we), .tok_wdata_i(tok_wdata),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx), .fill_data_i(fill_data),
    .evict_valid_i(evict_valid), .evict_idx_i(evict_idx), .evict_data_i(evict_data),
    .wb_data_o(wb_data), .acc_valid_i(acc_valid), .acc_op_i(acc_op),
    .acc_idx_i(acc_idx), .acc_off_i(acc_off), .tok_bits_o(tok_bits),
    .viol_o(viol), .viol_idx_o(viol_idx), .viol_off_o(viol_off)
  );

  // behavioural reference state
  logic [NL*CH-1:0] m_bits;
  logic [TW-1:0]    m_tok;
  logic             m_viol;
  logic [IW-1:0]    m_vidx;
  logic [OW-1:0]    m_voff;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [TW-1:0] mk_tok(int s);
    logic [TW-1:0] t;
    for (int i = 0; i < TW / 32; i++) t[i*32 +: 32] = 32'h9E3779B9 * 32'(s + i + 1);
    return t;
  endfunction

  task automatic chk(string tag, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    tok_we = 0; tok_wdata = '0; fill_valid = 0; fill_idx = '0; fill_data = '0;
    evict_valid = 0; evict_idx = '0; evict_data = '0;
    acc_valid = 0; acc_op = 2'd0; acc_idx = '0; acc_off = '0;
  endtask

  task automatic do_fill(int i, logic [TW-1:0] c0, logic [TW-1:0] c1);
    fill_valid = 1; fill_idx = IW'(i); fill_data = {c1, c0};
  endtask
  task automatic do_evict(int i, logic [LW-1:0] d);
    evict_valid = 1; evict_idx = IW'(i); evict_data = d;
  endtask
  task automatic do_acc(int op, int i, int off);
    acc_valid = 1; acc_op = 2'(op); acc_idx = IW'(i); acc_off = OW'(off);
  endtask

  // called after negedge with inputs set; compares outputs each clock
  task automatic step(string tag);
    logic [NL*CH-1:0] nb;
    logic [LW-1:0] exp_wb;
    logic nv;
    int b;
    #1;
    if (evict_valid) begin
      for (int c = 0; c < CH; c++)
        exp_wb[c*TW +: TW] = m_bits[int'(evict_idx)*CH + c] ? m_tok : evict_data[c*TW +: TW];
      chk(tag, "wb_data", wb_data, exp_wb);
    end
    nb = m_bits; nv = 0;
    if (evict_valid) for (int c = 0; c < CH; c++) nb[int'(evict_idx)*CH + c] = 1'b0;
    if (acc_valid) begin
      b = int'(acc_idx) * CH + int'(acc_off) / TB;
      if (acc_op < 2) begin
        if (m_bits[b]) begin nv = 1; m_vidx = acc_idx; m_voff = acc_off; end
      end else nb[b] = (acc_op == 2'd2);
    end
    if (fill_valid)
      for (int c = 0; c < CH; c++) nb[int'(fill_idx)*CH + c] = (fill_data[c*TW +: TW] == m_tok);
    if (tok_we) m_tok = tok_wdata;
    m_bits = nb; m_viol = nv;
    @(posedge clk);
    @(negedge clk);
    idle();
    chk(tag, "tok_bits", LW'(tok_bits), LW'(m_bits));
    chk(tag, "viol", LW'(viol), LW'(m_viol));
    if (m_viol) begin
      chk(tag, "viol_idx", LW'(viol_idx), LW'(m_vidx));
      chk(tag, "viol_off", LW'(viol_off), LW'(m_voff));
    end
  endtask

  initial begin
    logic [TW-1:0] t1, t2, ones;
    ones = '1; t1 = mk_tok(7); t2 = mk_tok(99);
    idle(); rst_n = 0;
    m_bits = '0; m_tok = '1; m_viol = 0; m_vidx = '0; m_voff = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1", "tok_bits", LW'(tok_bits), '0);
    chk("R1", "viol", LW'(viol), '0);
    step("R1");
    do_fill(1, ones, ones); step("R1");
    // R6 token write with same-cycle fill uses old token
    tok_we = 1; tok_wdata = t1; do_fill(2, t1, ones); step("R6");
    do_fill(3, t1, t2); step("R6");
    // R2 refill with mismatching data clears, then chunk1 only
    do_fill(3, t2, t2); step("R2");
    do_fill(3, ones, t1); step("R2");
    // R3 token set/clear, R8 offset edges
    do_acc(2, 4, 40); step("R3");
    do_acc(2, 4, 31); step("R8");
    do_acc(3, 4, 32); step("R3");
    do_acc(3, 4, 63); step("R3");
    // R4 ordinary access
    do_acc(0, 3, 63); step("R4");
    do_acc(0, 3, 0);  step("R4");
    do_acc(1, 3, 32); step("R4");
    do_acc(1, 6, 5);  step("R4");
    do_acc(0, 4, 31); step("R8");
    // R5 eviction regenerates token and clears
    do_evict(3, {t2, t2}); step("R5");
    do_acc(0, 3, 40); step("R5");
    do_evict(1, {t2, mk_tok(5)}); step("R5");
    // R7 same-cycle collisions
    do_fill(5, t1, t1); do_acc(3, 5, 0); step("R7");
    do_fill(5, t2, t1); do_acc(0, 5, 10); step("R7");
    do_acc(2, 6, 33); do_evict(6, {t1, t2}); step("R7");
    do_evict(6, {t1, t1}); do_fill(6, t1, t2); step("R7");
    do_fill(0, t1, t1); do_evict(6, {t2, t2}); do_acc(1, 6, 50); step("R7");
    // R6 new token applies to later fills
    tok_we = 1; tok_wdata = t2; step("R6");
    do_fill(7, t1, t2); step("R6");
    // random collisions across all functions
    for (int n = 0; n < 600; n++) begin
      logic [TW-1:0] pick [3];
      pick[0] = m_tok; pick[1] = t1; pick[2] = mk_tok(n);
      if ($urandom_range(0, 2) == 0) do_fill($urandom_range(0, 3),
        pick[$urandom_range(0, 2)], pick[$urandom_range(0, 2)]);
      if ($urandom_range(0, 3) == 0) do_evict($urandom_range(0, 3),
        {pick[$urandom_range(0, 2)], pick[$urandom_range(0, 2)]});
      if ($urandom_range(0, 1) == 0) do_acc($urandom_range(0, 3),
        $urandom_range(0, 3), $urandom_range(0, LB - 1));
      if ($urandom_range(0, 40) == 0) begin tok_we = 1; tok_wdata = pick[$urandom_range(1, 2)]; end
      step("R7");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule